// File: doc/BRIEF.md
# Gated Manchester Transmit Encoder

The block turns an NRZ bit stream into a Manchester II line code on a complementary pair of outputs. Its only timing source is a reference clock running at twice the bit rate. An internal divide-by-two produces the bit-rate clock, which leaves the block so that the logic feeding it can launch data on the same clock. Data and transmit enable are captured once per bit, at the boundary where the exported bit clock rises.

While the captured enable is high, each bit becomes two half-bit symbols. The first half carries the inverted bit and the second half carries the bit itself, so a 1 shows a rising mid-bit transition. When the captured enable is low, the output pair rests in an idle state. A select pin picks that state: either balanced, with both outputs at the same level, or a held logical high.

Top module: `manch_tx_encoder`

## Requirements
- R1: `bit_clk_o` is the reference divided by two. It rises once every two `clk_i` cycles and stays high for exactly one `clk_i` cycle.
- R2: `tx_data_i` and `tx_en_i` are captured only on the `clk_i` edge where `bit_clk_o` rises. Changes at any other time have no effect on the output pair for the bit in progress.
- R3: While the captured enable is 1 and the captured bit is d, `line_p_o` equals ~d in the first half-bit (`bit_clk_o` high) and d in the second half-bit (`bit_clk_o` low).
- R4: While encoding, `line_n_o` is always the complement of `line_p_o`.
- R5: While the captured enable is 0 and `idle_sel_i` is 1 (balanced idle), `line_p_o` and `line_n_o` both equal the parameter `BAL_LVL` (default 0).
- R6: While the captured enable is 0 and `idle_sel_i` is 0, `line_p_o` is 1 and `line_n_o` is 0.
- R7: An enable that rises in the middle of a bit does not start encoding until the next bit boundary.
- R8: The last bit captured with enable high is sent in full, both halves, before the pair goes idle. The captured enable only ever falls at a bit boundary.
- R9: While `rst_ni` is low, the divider phase is cleared so that `bit_clk_o` is 1, and the pair shows the idle state that `idle_sel_i` selects. After release, the first rising edge of `bit_clk_o` follows the second `clk_i` rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock at twice the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_data_i | input | 1 | NRZ data, captured at each bit boundary |
| tx_en_i | input | 1 | Transmit enable, captured at each bit boundary |
| idle_sel_i | input | 1 | Idle state select: 1 balanced, 0 held high |
| bit_clk_o | output | 1 | Exported bit-rate clock (reference / 2) |
| line_p_o | output | 1 | Positive line output |
| line_n_o | output | 1 | Negative line output |

## Verification
The in-RTL assertions check the following on every cycle:
- the bit clock toggles on each reference edge;
- the captured inputs hold still away from a boundary;
- the pair is complementary and makes a mid-bit transition while encoding;
- the pair matches the selected idle level;
- the captured enable falls only at a boundary.

The exact half-bit polarity against the data that was sent can only be shown by the bench's scenarios. The same holds for three other behaviours: the full final bit before idle, the deferred start of an enable raised mid-bit, and the phase after reset. The bench shows these by comparing each bit's two halves against the stimulus it queued, including stimulus with noise injected mid-bit.

// File: rtl/mtx_pkg.sv
`timescale 1ns/1ps
package mtx_pkg;
  typedef struct packed {
    logic p;
    logic n;
  } line_pair_t;

  localparam int unsigned HALF_CNT = 2;

  function automatic line_pair_t idle_pair(logic bal_sel, logic bal_lvl);
    line_pair_t r;
    if (bal_sel) begin
      r.p = bal_lvl;
      r.n = bal_lvl;
    end else begin
      r.p = 1'b1;
      r.n = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/mtx_clk_div.sv
`timescale 1ns/1ps
module mtx_clk_div (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o,
  output logic bit_clk_o,
  output logic bit_end_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign phase_o   = phase_q;
  assign bit_clk_o = ~phase_q;
  assign bit_end_o = phase_q;

  // R1
  bit_clk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (bit_clk_o != $past(bit_clk_o)));
endmodule

// File: rtl/mtx_in_sync.sv
`timescale 1ns/1ps
module mtx_in_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_end_i,
  input  logic data_i,
  input  logic en_i,
  output logic data_o,
  output logic en_o
);
  logic data_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (bit_end_i) begin
      data_q <= data_i;
      en_q   <= en_i;
    end
  end

  assign data_o = data_q;
  assign en_o   = en_q;

  // R2
  hold_mid_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_end_i |=> ($stable(data_q) && $stable(en_q)));
endmodule

// File: rtl/mtx_symbol_gen.sv
`timescale 1ns/1ps
module mtx_symbol_gen
  import mtx_pkg::*;
#(
  parameter logic BAL_LVL = 1'b0
) (
  input  logic       en_i,
  input  logic       data_i,
  input  logic       phase_i,
  input  logic       idle_sel_i,
  output line_pair_t pair_o
);
  logic half_val;

  // second half carries data, first half its complement
  assign half_val = phase_i ? data_i : ~data_i;

  always_comb begin
    if (en_i) begin
      pair_o.p = half_val;
      pair_o.n = ~half_val;
    end else begin
      pair_o = idle_pair(idle_sel_i, BAL_LVL);
    end
  end
endmodule

// File: rtl/manch_tx_encoder.sv
`timescale 1ns/1ps
module manch_tx_encoder
  import mtx_pkg::*;
#(
  parameter logic BAL_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_data_i,
  input  logic tx_en_i,
  input  logic idle_sel_i,
  output logic bit_clk_o,
  output logic line_p_o,
  output logic line_n_o
);
  logic       phase, bit_end;
  logic       data_q, en_q;
  line_pair_t pair;

  mtx_clk_div i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_o   (phase),
    .bit_clk_o (bit_clk_o),
    .bit_end_o (bit_end)
  );

  mtx_in_sync i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_end_i (bit_end),
    .data_i    (tx_data_i),
    .en_i      (tx_en_i),
    .data_o    (data_q),
    .en_o      (en_q)
  );

  mtx_symbol_gen #(.BAL_LVL(BAL_LVL)) i_sym (
    .en_i       (en_q),
    .data_i     (data_q),
    .phase_i    (phase),
    .idle_sel_i (idle_sel_i),
    .pair_o     (pair)
  );

  assign line_p_o = pair.p;
  assign line_n_o = pair.n;

  // R4
  enc_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> (line_p_o != line_n_o));

  // R3
  mid_bit_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && phase) |-> (line_p_o != $past(line_p_o)));

  // R5
  idle_bal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && idle_sel_i) |-> (line_p_o == BAL_LVL && line_n_o == BAL_LVL));

  // R6
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !idle_sel_i) |-> (line_p_o && !line_n_o));

  // R8
  en_fall_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> !phase);
endmodule

// File: tb/test_manch_tx_encoder.sv
`timescale 1ns/1ps
module test_manch_tx_encoder;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tx_data_i = 1'b0, tx_en_i = 1'b0, idle_sel_i = 1'b0;
  logic bit_clk_o, line_p_o, line_n_o;

  manch_tx_encoder i_manch_tx_encoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_data_i(tx_data_i), .tx_en_i(tx_en_i),
    .idle_sel_i(idle_sel_i), .bit_clk_o(bit_clk_o),
    .line_p_o(line_p_o), .line_n_o(line_n_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic  en;
    logic  d;
    logic  sel;
    string tg;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;

  task automatic chk(string r, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: sets inputs late in the bit, captured at next boundary
  task automatic drive(logic en, logic d, logic sel, bit noisy, string tg);
    item_t it;
    @(posedge bit_clk_o);
    if (noisy) begin
      #3;
      tx_data_i = ~tx_data_i;
      tx_en_i   = ~tx_en_i;
      #14;
    end else begin
      #17;
    end
    tx_en_i    = en;
    tx_data_i  = d;
    idle_sel_i = sel;
    it.en = en; it.d = d; it.sel = sel; it.tg = tg;
    q.push_back(it);
  endtask

  // monitor: one popped item per bit, both halves checked
  initial begin
    item_t it;
    wait (rst_ni);
    forever begin
      @(posedge bit_clk_o);
      if (q.size() > 0) begin
        it = q.pop_front();
        #5;
        chk("R1", "bit clk first half", bit_clk_o, 1'b1);
        if (it.en) begin
          chk({"R3 ", it.tg}, "p first half", line_p_o, ~it.d);
          chk("R4", "n first half", line_n_o, ~line_p_o);
        end else if (it.sel) begin
          chk({"R5 ", it.tg}, "p idle bal", line_p_o, 1'b0);
          chk({"R5 ", it.tg}, "n idle bal", line_n_o, 1'b0);
        end else begin
          chk({"R6 ", it.tg}, "p idle high", line_p_o, 1'b1);
          chk({"R6 ", it.tg}, "n idle high", line_n_o, 1'b0);
        end
        #10;
        chk("R1", "bit clk second half", bit_clk_o, 1'b0);
        if (it.en) begin
          chk({"R3 ", it.tg}, "p second half", line_p_o, it.d);
          chk("R4", "n second half", line_n_o, ~line_p_o);
        end else if (it.sel) begin
          chk({"R5 ", it.tg}, "p idle bal 2", line_p_o, 1'b0);
          chk({"R5 ", it.tg}, "n idle bal 2", line_n_o, 1'b0);
        end else begin
          chk({"R6 ", it.tg}, "p idle high 2", line_p_o, 1'b1);
          chk({"R6 ", it.tg}, "n idle high 2", line_n_o, 1'b0);
        end
      end
    end
  end

  // R1 period of the exported bit clock
  initial begin
    time t0;
    wait (rst_ni);
    @(posedge bit_clk_o);
    t0 = $time;
    for (int i = 0; i < 20; i++) begin
      @(posedge bit_clk_o);
      n_chk++;
      if ($time - t0 != 20) begin
        n_fail++;
        $display("FAIL R1 period: got %0t expected 20", $time - t0);
      end
      t0 = $time;
    end
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] lf;
    lf = 8'hA5;
    // R9 reset state, both idle selections
    #12;
    chk("R9", "bit clk in reset", bit_clk_o, 1'b1);
    chk("R9", "p reset high idle", line_p_o, 1'b1);
    chk("R9", "n reset high idle", line_n_o, 1'b0);
    idle_sel_i = 1'b1;
    #5;
    chk("R9", "p reset bal idle", line_p_o, 1'b0);
    chk("R9", "n reset bal idle", line_n_o, 1'b0);
    idle_sel_i = 1'b0;
    #13;
    rst_ni = 1'b1;
    #10;
    chk("R9", "bit clk after first edge", bit_clk_o, 1'b0);
    #10;
    chk("R9", "bit clk after second edge", bit_clk_o, 1'b1);

    // held-high idle, with mid-bit enable noise (R7)
    drive(1'b0, 1'b0, 1'b0, 1'b0, "R6");
    drive(1'b0, 1'b0, 1'b0, 1'b1, "R7");
    drive(1'b0, 1'b1, 1'b0, 1'b1, "R7");
    // frame, fixed pattern
    drive(1'b1, 1'b1, 1'b0, 1'b0, "R3");
    drive(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    drive(1'b1, 1'b1, 1'b0, 1'b0, "R3");
    drive(1'b1, 1'b1, 1'b0, 1'b0, "R3");
    drive(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    drive(1'b1, 1'b0, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // balanced idle, then a frame with mid-bit data noise (R2)
    drive(1'b0, 1'b0, 1'b1, 1'b0, "R5");
    drive(1'b0, 1'b1, 1'b1, 1'b1, "R7");
    drive(1'b1, 1'b0, 1'b1, 1'b0, "R2");
    drive(1'b1, 1'b1, 1'b1, 1'b1, "R2");
    drive(1'b1, 1'b0, 1'b1, 1'b1, "R2");
    drive(1'b1, 1'b1, 1'b1, 1'b1, "R8");
    drive(1'b0, 1'b1, 1'b1, 1'b0, "R8");
    // single-bit frame
    drive(1'b1, 1'b1, 1'b1, 1'b0, "R8");
    drive(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // pseudo-random frames, alternating idle selection
    for (int f = 0; f < 4; f++) begin
      for (int b = 0; b < 24; b++) begin
        drive(1'b1, lf[0], f[0], (b % 5) == 2, "R3");
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      end
      drive(1'b0, lf[1], f[0], 1'b0, "R8");
      drive(1'b0, lf[2], f[0], 1'b1, "R7");
    end
    wait (q.size() == 0);
    repeat (3) @(posedge bit_clk_o);
    #2;
    finish_run();
  end
endmodule